// File: doc/BRIEF.md
# Half-Rate to Full-Rate Word Aligner

This block carries a wide data word from a slow clock domain into a fast clock domain. The fast clock runs at exactly twice the slow frequency, and both clocks come from one source. The slow domain launches a fresh word on every slow rising edge. The fast domain has to take each word exactly once, with no slip and no repeat, even when the skew between the two clock trees eats most of the hold margin on a direct sample.

The block works out the phase of the slow clock from inside the fast domain. A single flop samples the slow clock itself on the falling edge of the fast clock. A second flop moves that sample onto the fast rising edge. From the retimed bit the block builds a capture enable that is high on every other fast cycle. The enable selects the fast rising edge that falls halfway through the slow word's valid window, which is the edge that coincides with the slow falling edge.

Only the one-bit phase sample has a half-period path. All data flops are loaded on fast rising edges under the enable, so each data bit has a full fast period of setup margin and a full fast period of hold margin. The captured word and a one-cycle valid strobe leave the block from registers.

Top module: `halfrate_aligner`

## Requirements
- R1: While `rst_n` is low at a fast rising edge, `out_vld` and `out_word` are zero after that edge.
- R2: On the first two fast rising edges after `rst_n` goes high, `out_vld` stays low.
- R3: `out_vld` is never high on two consecutive fast cycles. From the fourth fast edge after reset release onward, it toggles on every fast cycle.
- R4: Each `out_vld` pulse presents the word that was launched on the most recent slow rising edge. Words arrive in launch order, with none dropped and none repeated.
- R5: While `out_vld` is low, `out_word` keeps its previous value.
- R6: `out_vld` and `out_word` change only on the fast rising edge that coincides with a slow falling edge. After such an update, `out_vld` is high only while `clk_slow` is low.
- R7: The capture is correct for either slow phase at the moment reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast clock, twice the slow frequency |
| rst_n | input | 1 | Active-low synchronous reset, fast domain |
| clk_slow | input | 1 | Slow clock, sampled as a data signal for phase detection |
| in_word | input | W | Word launched on each slow rising edge |
| out_word | output | W | Captured word, fast domain |
| out_vld | output | 1 | One-cycle strobe marking a new `out_word` |

## Verification
On every slow rising edge, a new word is launched at the same instant as a fast rising edge. On that edge the block must not capture; it must capture one fast edge later. The bench aligns both clock trees exactly. It changes the data 1 ns after each slow edge, with patterns chosen so that every word differs from the one before. Each captured word is then compared with a queue holding exactly one pending launch: a capture on the wrong edge shows up as a duplicate, a wrong word, or a drop. The end of warm-up can also coincide with the first enable. The bench therefore releases reset once just after a slow rising edge and once just after a slow falling edge, and checks the warm-up and alternation rules each time.

// File: rtl/halfrate_aligner.sv
module halfrate_aligner #(
  parameter int W      = 68,
  parameter int WARMUP = 2
) (
  input  logic         clk_fast,
  input  logic         rst_n,
  input  logic         clk_slow,
  input  logic [W-1:0] in_word,
  output logic [W-1:0] out_word,
  output logic         out_vld
);
  localparam int CW = $clog2(WARMUP + 1);

  logic          ph_fall;
  logic          ph_rise;
  logic [CW-1:0] warm_cnt;
  logic          ready;
  logic          cap_en;

  // the only half-period path: slow clock sampled on the fast falling edge
  always_ff @(negedge clk_fast) begin
    if (!rst_n) ph_fall <= 1'b0;
    else        ph_fall <= clk_slow;
  end

  always_ff @(posedge clk_fast) begin
    if (!rst_n) ph_rise <= 1'b0;
    else        ph_rise <= ph_fall;
  end

  always_ff @(posedge clk_fast) begin
    if (!rst_n)      warm_cnt <= '0;
    else if (!ready) warm_cnt <= warm_cnt + 1'b1;
  end

  assign ready  = (warm_cnt == CW'(WARMUP));
  assign cap_en = ready & ~ph_rise;

  always_ff @(posedge clk_fast) begin
    if (!rst_n) begin
      out_word <= '0;
      out_vld  <= 1'b0;
    end else begin
      out_vld <= cap_en;
      if (cap_en) out_word <= in_word;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk_fast)
    !rst_n |=> (!out_vld && out_word == '0));

  assert_warmup_first_R2: assert property (@(posedge clk_fast) disable iff (!rst_n)
    $past(!rst_n) |-> !out_vld);

  assert_warmup_second_R2: assert property (@(posedge clk_fast) disable iff (!rst_n)
    $past(!rst_n, 2) |-> !out_vld);

  assert_no_back_to_back_R3: assert property (@(posedge clk_fast) disable iff (!rst_n)
    out_vld |=> !out_vld);

  assert_alternate_R3: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (ready && $past(ready) && $past(rst_n)) |=> (out_vld != $past(out_vld)));

  assert_hold_word_R5: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (!out_vld && $past(rst_n)) |-> $stable(out_word));
endmodule

// File: tb/halfrate_aligner_bench.sv
`timescale 1ns/1ps
module halfrate_aligner_bench;
  localparam int W = 68;

  logic         clk_fast = 1'b0;
  logic         clk_slow = 1'b0;
  logic         rst_n    = 1'b0;
  logic [W-1:0] in_word  = '0;
  logic [W-1:0] out_word;
  logic         out_vld;

  int checks   = 0;
  int failures = 0;
  int mode     = 0;
  int seq      = 0;
  logic [W-1:0] expq[$];

  halfrate_aligner #(.W(W)) u_halfrate_aligner (
    .clk_fast(clk_fast), .rst_n(rst_n), .clk_slow(clk_slow),
    .in_word(in_word), .out_word(out_word), .out_vld(out_vld)
  );

  initial forever #2.5 clk_fast = ~clk_fast;
  initial begin
    #2.5;
    forever begin clk_slow = 1'b1; #5; clk_slow = 1'b0; #5; end
  end

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  function automatic logic [W-1:0] mk(input int s, input int m);
    logic [W-1:0] v;
    case (m)
      0: v = {4'h5, 32'(s), 32'(s * 7 + 3)};
      1: v = s[0] ? '1 : '0;
      2: v = W'(1) << (s % W);
      default: v = {4'(s), $urandom, $urandom};
    endcase
    return v;
  endfunction

  // driver: one word per slow rising edge, pushed into the scoreboard
  initial begin
    forever begin
      @(posedge clk_slow);
      #1;
      in_word = mk(seq, mode);
      expq.push_back(in_word);
      seq++;
    end
  end

  // monitor
  initial begin
    int since = 0;
    bit first = 1'b1;
    logic prev_vld = 1'b0;
    logic [W-1:0] prev_word = '0;
    forever begin
      @(posedge clk_fast);
      #1;
      if (!rst_n) begin
        check(!out_vld && out_word == '0, "R1", {out_vld, out_word}, '0);
        since = 0; first = 1'b1; prev_vld = 1'b0; prev_word = '0;
      end else begin
        since++;
        if (since <= 2) check(!out_vld, "R2", W'(out_vld), '0);
        if (prev_vld) check(!out_vld, "R3 back-to-back", W'(out_vld), '0);
        if (since >= 4) check(out_vld != prev_vld, "R3 alternate", W'(out_vld), W'(!prev_vld));
        if (!out_vld) check(out_word == prev_word, "R5", out_word, prev_word);
        if (out_vld) begin
          check(clk_slow == 1'b0, "R6 edge", W'(clk_slow), '0);
          if (first) begin
            while (expq.size() > 1) void'(expq.pop_front());
            first = 1'b0;
          end
          check(expq.size() == 1, "R4 queue depth", W'(expq.size()), W'(1));
          if (expq.size() > 0) begin
            logic [W-1:0] e;
            e = expq.pop_front();
            check(out_word == e, "R4 word", out_word, e);
          end
        end
        prev_vld = out_vld;
        prev_word = out_word;
      end
    end
  end

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    repeat (6) @(posedge clk_fast);
    // R7: release just after a slow rising edge
    @(posedge clk_slow); #2; rst_n = 1'b1;
    mode = 0; repeat (150) @(posedge clk_slow);
    mode = 1; repeat (100) @(posedge clk_slow);
    mode = 2; repeat (100) @(posedge clk_slow);
    // R1 mid-run reset, then R7: release just after a slow falling edge
    @(posedge clk_fast); #2; rst_n = 1'b0;
    repeat (5) @(posedge clk_fast);
    @(negedge clk_slow); #2; rst_n = 1'b1;
    mode = 3; repeat (200) @(posedge clk_slow);
    mode = 0; repeat (50) @(posedge clk_slow);
    #3;
    finish_run();
  end
endmodule